// File: doc/BRIEF.md
# Shift, Rotate and Bitfield Execution Unit

This block is the bit-manipulation lane of a 32-bit integer execution stage. It takes a 4-bit operation code, two register operands (`rs_val`, `rt_val`), a 5-bit position or shift-amount field and a 5-bit size field. From these it returns a single 32-bit result. It is purely combinational, so the result follows the inputs in the same cycle, and a pipeline register outside the block captures it.

The unit covers these operations:
- logical left and right shifts, by the immediate field or by a register;
- arithmetic right shift;
- rotate right, by the immediate field or by a register;
- a byte swap inside each 16-bit half;
- sign extension of a byte or a halfword;
- bitfield extract and bitfield insert.

An operation code outside the defined set raises `illegal` and forces the result to zero.

Top module: `bitops_exec`

## Requirements
- R1: Operation codes are 0 SLL-imm, 1 SRL-imm, 2 SRA-imm, 3 ROTR-imm, 4 SLL-reg, 5 SRL-reg, 6 SRA-reg, 7 ROTR-reg, 8 byte-swap-in-halves, 9 sign-extend-byte, 10 sign-extend-half, 11 extract, 12 insert. The immediate shifts move `rt_val` by `pos_amt`, and `rs_val` has no effect on them.
- R2: Arithmetic right shift fills every vacated bit with bit 31 of `rt_val`. The logical shifts fill with zero.
- R3: Immediate rotate right returns `rt_val` rotated right by `pos_amt`. With an amount of 0 it returns `rt_val` unchanged.
- R4: The register shifts and the register rotate take their amount from `rs_val[4:0]` only. Bits 31:5 of `rs_val` and the `pos_amt` field have no effect on them.
- R5: A register rotate whose amount `rs_val[4:0]` is 0 returns `rt_val` unchanged.
- R6: The byte swap returns, in each 16-bit half of `rt_val`, its two bytes exchanged.
- R7: Sign-extend-byte copies `rt_val[7]` into bits 31:8. Sign-extend-half copies `rt_val[15]` into bits 31:16.
- R8: Extract returns `rs_val` shifted right by `pos_amt` and masked to `size_m1`+1 low bits. With `size_m1` = 31 the mask is all ones.
- R9: Insert places the low `size_m1`+1 bits of `rs_val` at bit `pos_amt` and keeps every other bit of `rt_val`. Bits of `rs_val` above the field have no effect.
- R10: Codes 13 to 15 drive `illegal` high and the result to zero. Every defined code drives `illegal` low.
- R11: The result depends on the current inputs only. It holds no state, and it is valid in the same cycle that the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select (encoding in R1) |
| rs_val | input | 32 | Source operand: shift amount source, extract/insert source |
| rt_val | input | 32 | Target operand: shifted/rotated value, insert destination |
| pos_amt | input | 5 | Immediate shift amount or bitfield position |
| size_m1 | input | 5 | Bitfield size minus one |
| result | output | 32 | Operation result |
| illegal | output | 1 | High for an undefined operation code |

## Verification
The shifts are tried with amounts 0, a mid value and 31. They are also tried with `rt_val` values whose top bit is set and clear, which separates a logical fill from an arithmetic fill and a rotate from a plain shift. The register forms get `rs_val` values with junk in bits 31:5 and a masked amount of zero. A unit that uses the whole register, or that mishandles the zero rotate, gives a visibly different result. The bitfield operations run at the full 32-bit size, at the top edge position and with junk bits in `rs_val` above the field. These cases expose a mask that overflows or a field that is not masked. The sign extensions use inputs with the sign bit set and clear and with nonzero upper bits.

// File: rtl/bitops_pkg.sv
// Package: shared operation encoding for the shift/rotate/bitfield unit.
// Assumes a 4-bit operation code; codes above OP_INS are undefined.
package bitops_pkg;
    typedef enum logic [3:0] {
        OP_SLL   = 4'd0,
        OP_SRL   = 4'd1,
        OP_SRA   = 4'd2,
        OP_ROTR  = 4'd3,
        OP_SLLV  = 4'd4,
        OP_SRLV  = 4'd5,
        OP_SRAV  = 4'd6,
        OP_ROTRV = 4'd7,
        OP_WSWAP = 4'd8,
        OP_SEXTB = 4'd9,
        OP_SEXTH = 4'd10,
        OP_EXT   = 4'd11,
        OP_INS   = 4'd12
    } bitop_e;

    localparam logic [3:0] OP_LAST = 4'd12;
endpackage

// File: rtl/bitops_shift.sv
// Module: barrel shifter/rotator.
// kind: 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right.
// Assumes the amount has already been selected and masked to SHW bits.
module bitops_shift #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [1:0]      kind,
    input  logic [SHW-1:0]  amt,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] res
);
    logic [2*XLEN-1:0] doubled;

    // Rotate via a doubled word; amount 0 naturally returns val.
    always_comb doubled = {val, val} >> amt;

    // Pick the shift flavour.
    always_comb begin
        case (kind)
            2'd0:    res = val << amt;
            2'd1:    res = val >> amt;
            2'd2:    res = $unsigned($signed(val) >>> amt);
            default: res = doubled[XLEN-1:0];
        endcase
    end
endmodule

// File: rtl/bitops_bytes.sv
// Module: byte swap within each 16-bit half, and byte/halfword sign extension.
// sel: 0 swap, 1 sign-extend byte, 2 sign-extend half. Assumes XLEN % 16 == 0.
module bitops_bytes #(
    parameter int XLEN = 32,
    localparam int NHALF = XLEN / 16
) (
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] swapped;

    // One swap cell per halfword.
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign swapped[16*h +: 8]     = val[16*h + 8 +: 8];
        assign swapped[16*h + 8 +: 8] = val[16*h +: 8];
    end

    // Choose swap or one of the sign extensions.
    always_comb begin
        case (sel)
            2'd1:    res = {{(XLEN-8){val[7]}}, val[7:0]};
            2'd2:    res = {{(XLEN-16){val[15]}}, val[15:0]};
            default: res = swapped;
        endcase
    end
endmodule

// File: rtl/bitops_field.sv
// Module: bitfield extract and insert.
// Field width is size_m1+1, computed one bit wider so a full-width field
// yields an all-ones mask. Fields running past the MSB are truncated.
module bitops_field #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            do_insert,
    input  logic [SHW-1:0]  pos,
    input  logic [SHW-1:0]  size_m1,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    output logic [XLEN-1:0] res
);
    logic [SHW:0]    fwidth;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] placed_mask;

    // Mask of fwidth ones; a shift by XLEN gives zero, so inverse is all ones.
    always_comb begin
        fwidth      = {1'b0, size_m1} + {{SHW{1'b0}}, 1'b1};
        mask        = ~({XLEN{1'b1}} << fwidth);
        placed_mask = mask << pos;
    end

    // Extract or insert.
    always_comb begin
        if (do_insert) res = ((src & mask) << pos) | (dst & ~placed_mask);
        else           res = (src >> pos) & mask;
    end
endmodule

// File: rtl/bitops_exec.sv
// Module: top of the combinational shift/rotate/bitfield unit.
// Decodes the operation, routes operands to the three sub-units and selects
// the result. Undefined codes give zero and raise illegal. No state.
module bitops_exec #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [SHW-1:0]  pos_amt,
    input  logic [SHW-1:0]  size_m1,
    output logic [XLEN-1:0] result,
    output logic            illegal
);
    import bitops_pkg::*;

    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] sh_res, by_res, fd_res;
    logic [1:0]      by_sel;

    // Register forms (bit 2 of the code) take the amount from rs low bits.
    always_comb sh_amt = op_code[2] ? rs_val[SHW-1:0] : pos_amt;

    // Byte-unit selector from the low code bits.
    always_comb by_sel = (op_code == OP_SEXTB) ? 2'd1 :
                         (op_code == OP_SEXTH) ? 2'd2 : 2'd0;

    bitops_shift #(.XLEN(XLEN)) u_shift (
        .kind (op_code[1:0]),
        .amt  (sh_amt),
        .val  (rt_val),
        .res  (sh_res)
    );

    bitops_bytes #(.XLEN(XLEN)) u_bytes (
        .sel (by_sel),
        .val (rt_val),
        .res (by_res)
    );

    bitops_field #(.XLEN(XLEN)) u_field (
        .do_insert (op_code == OP_INS),
        .pos       (pos_amt),
        .size_m1   (size_m1),
        .src       (rs_val),
        .dst       (rt_val),
        .res       (fd_res)
    );

    // Final result select and illegal-code flag.
    always_comb begin
        illegal = 1'b0;
        case (op_code)
            OP_SLL, OP_SRL, OP_SRA, OP_ROTR,
            OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV: result = sh_res;
            OP_WSWAP, OP_SEXTB, OP_SEXTH:        result = by_res;
            OP_EXT, OP_INS:                      result = fd_res;
            default: begin
                result  = '0;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bitops_exec_chk.sv
// Checker: immediate assertions on the combinational unit's port behaviour.
// Assumes the bound unit is purely combinational, so checks run in always_comb.
module bitops_exec_chk #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input logic [3:0]      op_code,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic [SHW-1:0]  pos_amt,
    input logic [SHW-1:0]  size_m1,
    input logic [XLEN-1:0] result,
    input logic            illegal
);
    // Port-level property checks.
    always_comb begin
        if (op_code > bitops_pkg::OP_LAST) begin
            p_illegal_zero_r10: assert (illegal && result == '0)
                else $error("illegal code must zero result");
        end else begin
            p_legal_noerr_r10: assert (!illegal)
                else $error("defined code flagged illegal");
        end
        if (op_code == 4'd3 && pos_amt == '0) begin
            p_rotr_zero_r3: assert (result == rt_val)
                else $error("rotate by 0 changed value");
        end
        if (op_code == 4'd7 && rs_val[SHW-1:0] == '0) begin
            p_rotrv_zero_r5: assert (result == rt_val)
                else $error("register rotate by 0 changed value");
        end
        if (op_code == 4'd9) begin
            p_sextb_fill_r7: assert (result[XLEN-1:8] == {(XLEN-8){rt_val[7]}}
                                     && result[7:0] == rt_val[7:0])
                else $error("byte sign extension wrong");
        end
        if (op_code == 4'd11 && pos_amt == '0 && size_m1 == '1) begin
            p_ext_fullmask_r8: assert (result == rs_val)
                else $error("full-width extract not identity");
        end
    end
endmodule

bind bitops_exec bitops_exec_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_bitops_exec.sv
// Bench: walks a vector table, then directed checks for reset and corners.
module sim_bitops_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic [4:0]  pos_amt = '0, size_m1 = '0;
    logic [31:0] result;
    logic        illegal;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    bitops_exec u0 (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] rs;
        logic [31:0] rt;
        logic [4:0]  sa;
        logic [4:0]  sz;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'hFFFF_FFFF, 32'h0000_00FF, 5'd4,  5'd0,  32'h0000_0FF0, 1'b0}, // R1 rs ignored
        '{4'd1,  32'h0,         32'h8000_0000, 5'd31, 5'd0,  32'h0000_0001, 1'b0}, // R1/R2 zero fill
        '{4'd2,  32'h0,         32'h8000_0000, 5'd4,  5'd0,  32'hF800_0000, 1'b0}, // R2 sign fill
        '{4'd2,  32'h0,         32'h7000_0000, 5'd4,  5'd0,  32'h0700_0000, 1'b0}, // R2 positive
        '{4'd3,  32'h0,         32'h1234_5678, 5'd8,  5'd0,  32'h7812_3456, 1'b0}, // R3
        '{4'd3,  32'h0,         32'hDEAD_BEEF, 5'd0,  5'd0,  32'hDEAD_BEEF, 1'b0}, // R3 zero
        '{4'd3,  32'h0,         32'h0000_0001, 5'd31, 5'd0,  32'h0000_0002, 1'b0}, // R3 max
        '{4'd4,  32'h0000_0024, 32'h0000_0001, 5'd7,  5'd0,  32'h0000_0010, 1'b0}, // R4
        '{4'd5,  32'hFFFF_FFE8, 32'hFF00_0000, 5'd3,  5'd0,  32'h00FF_0000, 1'b0}, // R4
        '{4'd6,  32'h0000_0020, 32'h8000_0001, 5'd9,  5'd0,  32'h8000_0001, 1'b0}, // R4 masked 0
        '{4'd6,  32'h0000_0004, 32'h8000_0000, 5'd0,  5'd0,  32'hF800_0000, 1'b0}, // R2 reg form
        '{4'd7,  32'h0000_0044, 32'h1234_5678, 5'd0,  5'd0,  32'h8123_4567, 1'b0}, // R4 rotate
        '{4'd7,  32'h0000_0060, 32'hCAFE_F00D, 5'd5,  5'd0,  32'hCAFE_F00D, 1'b0}, // R5
        '{4'd8,  32'hFFFF_FFFF, 32'h1122_3344, 5'd0,  5'd0,  32'h2211_4433, 1'b0}, // R6
        '{4'd9,  32'h0,         32'h0000_0080, 5'd0,  5'd0,  32'hFFFF_FF80, 1'b0}, // R7
        '{4'd9,  32'h0,         32'h1234_567F, 5'd0,  5'd0,  32'h0000_007F, 1'b0}, // R7
        '{4'd10, 32'h0,         32'h0000_8001, 5'd0,  5'd0,  32'hFFFF_8001, 1'b0}, // R7
        '{4'd10, 32'h0,         32'hABCD_7FFF, 5'd0,  5'd0,  32'h0000_7FFF, 1'b0}, // R7
        '{4'd11, 32'h1234_5678, 32'h0,         5'd8,  5'd7,  32'h0000_0056, 1'b0}, // R8
        '{4'd11, 32'hDEAD_BEEF, 32'h0,         5'd0,  5'd31, 32'hDEAD_BEEF, 1'b0}, // R8 full
        '{4'd11, 32'hA000_0000, 32'h0,         5'd28, 5'd3,  32'h0000_000A, 1'b0}, // R8 top
        '{4'd12, 32'h0000_00AB, 32'hFFFF_FFFF, 5'd8,  5'd7,  32'hFFFF_ABFF, 1'b0}, // R9
        '{4'd12, 32'h1234_5678, 32'h0,         5'd0,  5'd31, 32'h1234_5678, 1'b0}, // R9 full
        '{4'd12, 32'hFFFF_FFF5, 32'h0,         5'd4,  5'd2,  32'h0000_0050, 1'b0}, // R9 junk rs
        '{4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1,  5'd1,  32'h0,         1'b1}, // R10
        '{4'd14, 32'h1234_5678, 32'h8765_4321, 5'd0,  5'd0,  32'h0,         1'b1}, // R10
        '{4'd15, 32'h0,         32'h0000_0001, 5'd0,  5'd0,  32'h0,         1'b1}  // R10
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:         return "R1";
            4'd2:               return "R2";
            4'd3:               return "R3";
            4'd4, 4'd5, 4'd6:   return "R4";
            4'd7:               return "R5";
            4'd8:               return "R6";
            4'd9, 4'd10:        return "R7";
            4'd11:              return "R8";
            4'd12:              return "R9";
            default:            return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] exp_res,
                         input logic exp_err);
        checks++;
        if (result !== exp_res || illegal !== exp_err) begin
            errors++;
            $display("FAIL %s op=%0d result=%h illegal=%b expected result=%h illegal=%b",
                     req, op_code, result, illegal, exp_res, exp_err);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [31:0] rs,
                         input logic [31:0] rt, input logic [4:0] sa,
                         input logic [4:0] sz);
        @(posedge clk);
        op_code = op; rs_val = rs; rt_val = rt; pos_amt = sa; size_m1 = sz;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // Reset state: all-zero inputs give a zero result, no error (R1).
        @(negedge clk);
        check("R1", 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].rs, VECS[i].rt, VECS[i].sa, VECS[i].sz);
            check(req_of(VECS[i].op), VECS[i].exp, VECS[i].err);
        end

        // R4: pos_amt has no effect on a register shift.
        apply(4'd4, 32'h0000_0003, 32'h0000_0001, 5'd17, 5'd0);
        check("R4", 32'h0000_0008, 1'b0);
        // R9: full-width insert overwrites the whole target.
        apply(4'd12, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 5'd0, 5'd31);
        check("R9", 32'h0F0F_0F0F, 1'b0);
        // R11: result changes with inputs alone, no clock edge between.
        op_code = 4'd0; rs_val = 32'h0; rt_val = 32'h0000_0001; pos_amt = 5'd1;
        size_m1 = 5'd0;
        #1 check("R11", 32'h0000_0002, 1'b0);
        pos_amt = 5'd31;
        #1 check("R11", 32'h8000_0000, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule